// File: doc/BRIEF.md
# Dual-Mode Inter-Thread Mailbox Cell

This block is one storage cell shared by up to 64 hardware threads, used either to pass data words between threads or to synchronise them. A mode bit chooses the behaviour. As a queue, the cell holds up to four 64-bit words in a circular buffer and returns them oldest first. As a counting semaphore, it keeps one 64-bit count in its first data slot. A write raises the count. A read takes one unit from the count and returns the value the count had before the read.

An access that cannot proceed does not stall the cell. Such an access is a push to a full queue, a pop from an empty queue, or a read of a zero count. The cell marks the requesting thread in a 64-bit blocked bitmap and answers with a blocked status. When a later access changes the empty or full state, the cell hands the whole bitmap to the scheduler on a one-cycle wake pulse and clears the bitmap. A trap bit turns every would-block access into a trap response instead. A status tag exposes the mode, the flags, the fill count and the log2 of the depth. Writing the configuration resets the cell into the selected mode.

Top module: `itc_cell`

## Requirements
- R1: After reset the tag reads queue mode, Empty 1, Full 0, Trap 0 and count 0. The tag layout is: bit 0 Empty, bit 1 Full, bit 2 Trap, bit 3 mode (1 = queue, 0 = semaphore), bits 6:4 count, bits 9:7 log2 of depth (2), and all other bits zero.
- R2: In queue mode, a push to a non-full cell stores the data and raises the count by one. Full reads 1 exactly when the count is 4, and Empty reads 1 exactly when the count is 0.
- R3: In queue mode, a pop from a non-empty cell returns the oldest stored word on `rspData` and lowers the count by one. Words leave in push order, including when the storage index wraps from slot 3 to slot 0.
- R4: In semaphore mode, a write adds one to the count and holds it at the maximum value. A read of a nonzero count returns the count before the read and subtracts one. Empty reads 1 exactly when the count is 0. Full and the tag count field stay 0.
- R5: With Trap 0, a would-block access sets bit `accTid` of `blockedMap` and returns `rspBlocked` 1 with `rspData` 0. It changes neither the stored data nor the count.
- R6: When a successful access changes Empty or Full while `blockedMap` is nonzero, the next cycle shows `wakeValid` 1 with `wakeMask` equal to the bitmap before that access, and `blockedMap` reads 0. At all other times `wakeValid` is 0 and `wakeMask` is 0.
- R7: With Trap 1, a would-block access returns `rspTrap` 1 and `rspBlocked` 0. The bitmap and the cell contents stay unchanged.
- R8: A configuration write loads the mode and Trap bits, sets the count, the oldest index and the semaphore value to 0, sets Empty to 1 and clears Full. The bitmap is kept. An access in the same cycle is ignored and gives no response.
- R9: Every access that is not ignored yields `rspValid` 1 in the following cycle. `rspData` is 0 except after a successful read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgFifoMode | input | 1 | Mode to load: 1 queue, 0 semaphore |
| cfgTrap | input | 1 | Trap bit to load |
| accEn | input | 1 | Access request |
| accWrite | input | 1 | 1 push/write, 0 pop/read |
| accTid | input | 6 | Requesting thread ID |
| accData | input | 64 | Data to push |
| rspValid | output | 1 | Response for last cycle's access |
| rspBlocked | output | 1 | Access blocked and recorded |
| rspTrap | output | 1 | Access would block, trap raised |
| rspData | output | 64 | Read data |
| wakeValid | output | 1 | Wake pulse |
| wakeMask | output | 64 | Threads to wake |
| blockedMap | output | 64 | Current blocked-thread bitmap |
| tagWord | output | 16 | Status tag |

## Verification
A wrong count or oldest index shows up on the first pop after the fault, as a data word out of order or as a count field that disagrees with the reference. Flag errors show in the tag one cycle after the access that caused them. Bitmap errors appear on `blockedMap` as soon as they happen and again on the wake mask. Because the reference model is compared on every clock, a bad internal state is reported within one or two cycles of its first visible effect.

// File: rtl/itc_cell_pkg.sv
package itc_cell_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic semInc;
    logic semDec;
    logic clear;
  } itcStrobes_t;
endpackage

// File: rtl/itc_cell_ctrl.sv
module itc_cell_ctrl
  import itc_cell_pkg::*;
#(
  parameter int DEPTH_LOG2 = 2,
  parameter int THREADS    = 64,
  localparam int DEPTH     = 1 << DEPTH_LOG2,
  localparam int CNT_W     = DEPTH_LOG2 + 1,
  localparam int TID_W     = $clog2(THREADS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgFifoMode,
  input  logic               cfgTrap,
  input  logic               accEn,
  input  logic               accWrite,
  input  logic [TID_W-1:0]   accTid,
  input  logic [CNT_W-1:0]   dpCount,
  input  logic               semIsZero,
  input  logic               semIsOne,
  input  logic               semIsMax,
  output itcStrobes_t        strb,
  output logic               fifoMode,
  output logic               trapEn,
  output logic               emptyQ,
  output logic               fullQ,
  output logic [THREADS-1:0] blockMap,
  output logic               rspValidQ,
  output logic               rspBlockedQ,
  output logic               rspTrapQ,
  output logic               wakeValidQ,
  output logic [THREADS-1:0] wakeMaskQ
);

  logic accLive;
  logic wouldBlock;
  logic go;
  logic emptyNext;
  logic fullNext;
  logic flagChange;
  logic doWake;
  logic doBlock;
  logic doTrap;

  assign accLive = accEn && !cfgWrEn;

  always_comb begin
    if (fifoMode) wouldBlock = accWrite ? fullQ : emptyQ;
    else          wouldBlock = !accWrite && emptyQ;
  end

  assign go      = accLive && !wouldBlock;
  assign doBlock = accLive && wouldBlock && !trapEn;
  assign doTrap  = accLive && wouldBlock && trapEn;

  always_comb begin
    strb        = '0;
    strb.clear  = cfgWrEn;
    strb.push   = go && fifoMode && accWrite;
    strb.pop    = go && fifoMode && !accWrite;
    strb.semInc = go && !fifoMode && accWrite && !semIsMax;
    strb.semDec = go && !fifoMode && !accWrite;
  end

  always_comb begin
    emptyNext = emptyQ;
    fullNext  = fullQ;
    if (fifoMode) begin
      if (accWrite) begin
        emptyNext = 1'b0;
        fullNext  = (dpCount == CNT_W'(DEPTH - 1));
      end else begin
        emptyNext = (dpCount == CNT_W'(1));
        fullNext  = 1'b0;
      end
    end else begin
      fullNext  = 1'b0;
      emptyNext = accWrite ? 1'b0 : semIsOne;
    end
  end

  assign flagChange = go && ((emptyNext != emptyQ) || (fullNext != fullQ));
  assign doWake     = flagChange && (|blockMap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoMode <= 1'b1;
      trapEn   <= 1'b0;
      emptyQ   <= 1'b1;
      fullQ    <= 1'b0;
    end else if (cfgWrEn) begin
      fifoMode <= cfgFifoMode;
      trapEn   <= cfgTrap;
      emptyQ   <= 1'b1;
      fullQ    <= 1'b0;
    end else if (go) begin
      emptyQ   <= emptyNext;
      fullQ    <= fullNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blockMap <= '0;
    end else if (doWake) begin
      blockMap <= '0;
    end else if (doBlock) begin
      blockMap <= blockMap | (THREADS'(1) << accTid);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValidQ   <= 1'b0;
      rspBlockedQ <= 1'b0;
      rspTrapQ    <= 1'b0;
      wakeValidQ  <= 1'b0;
      wakeMaskQ   <= '0;
    end else begin
      rspValidQ   <= accLive;
      rspBlockedQ <= doBlock;
      rspTrapQ    <= doTrap;
      wakeValidQ  <= doWake;
      wakeMaskQ   <= doWake ? blockMap : '0;
    end
  end

  // R2
  full_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullQ |-> (dpCount == CNT_W'(DEPTH)));

  // R1
  empty_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyQ == (fifoMode ? (dpCount == '0) : semIsZero));

  // R5
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspBlockedQ |-> (dpCount == $past(dpCount)));

  // R6
  wake_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeValidQ |-> ((emptyQ != $past(emptyQ)) || (fullQ != $past(fullQ))));

  // R7
  trap_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspTrapQ |-> (blockMap == $past(blockMap)));

endmodule

// File: rtl/itc_cell_dp.sv
module itc_cell_dp
  import itc_cell_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int DEPTH_LOG2 = 2,
  localparam int DEPTH     = 1 << DEPTH_LOG2,
  localparam int PTR_W     = DEPTH_LOG2,
  localparam int CNT_W     = DEPTH_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  itcStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic              semIsZero,
  output logic              semIsOne,
  output logic              semIsMax,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  oldest;
  logic [PTR_W-1:0]  wrIdx;

  assign wrIdx     = oldest + count[PTR_W-1:0];
  assign semIsZero = (slots[0] == '0);
  assign semIsOne  = (slots[0] == DATA_W'(1));
  assign semIsMax  = &slots[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_sem
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               slots[i] <= '0;
        else if (strb.clear)                     slots[i] <= '0;
        else if (strb.semInc)                    slots[i] <= slots[i] + DATA_W'(1);
        else if (strb.semDec)                    slots[i] <= slots[i] - DATA_W'(1);
        else if (strb.push && wrIdx == PTR_W'(i)) slots[i] <= wrData;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               slots[i] <= '0;
        else if (strb.push && wrIdx == PTR_W'(i)) slots[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oldest <= '0;
      count  <= '0;
    end else if (strb.clear) begin
      oldest <= '0;
      count  <= '0;
    end else if (strb.push) begin
      count  <= count + CNT_W'(1);
    end else if (strb.pop) begin
      oldest <= oldest + PTR_W'(1);
      count  <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strb.pop)    rdData <= slots[oldest];
    else if (strb.semDec) rdData <= slots[0];
    else                  rdData <= '0;
  end

  // R8
  clear_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (count == '0 && oldest == '0 && slots[0] == '0));

  // R3
  pop_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> (oldest == PTR_W'($past(oldest) + PTR_W'(1))));

endmodule

// File: rtl/itc_cell.sv
module itc_cell
  import itc_cell_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int DEPTH_LOG2 = 2,
  parameter int THREADS    = 64,
  localparam int CNT_W     = DEPTH_LOG2 + 1,
  localparam int TID_W     = $clog2(THREADS),
  localparam int TAG_W     = 16,
  localparam int PAD_W     = TAG_W - 3 - CNT_W - 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgFifoMode,
  input  logic               cfgTrap,
  input  logic               accEn,
  input  logic               accWrite,
  input  logic [TID_W-1:0]   accTid,
  input  logic [DATA_W-1:0]  accData,
  output logic               rspValid,
  output logic               rspBlocked,
  output logic               rspTrap,
  output logic [DATA_W-1:0]  rspData,
  output logic               wakeValid,
  output logic [THREADS-1:0] wakeMask,
  output logic [THREADS-1:0] blockedMap,
  output logic [TAG_W-1:0]   tagWord
);

  itcStrobes_t      strb;
  logic [CNT_W-1:0] dpCount;
  logic             semIsZero;
  logic             semIsOne;
  logic             semIsMax;
  logic             fifoMode;
  logic             trapEn;
  logic             emptyQ;
  logic             fullQ;

  itc_cell_ctrl #(.DEPTH_LOG2(DEPTH_LOG2), .THREADS(THREADS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgFifoMode(cfgFifoMode), .cfgTrap(cfgTrap),
    .accEn(accEn), .accWrite(accWrite), .accTid(accTid),
    .dpCount(dpCount), .semIsZero(semIsZero), .semIsOne(semIsOne), .semIsMax(semIsMax),
    .strb(strb), .fifoMode(fifoMode), .trapEn(trapEn), .emptyQ(emptyQ), .fullQ(fullQ),
    .blockMap(blockedMap), .rspValidQ(rspValid), .rspBlockedQ(rspBlocked),
    .rspTrapQ(rspTrap), .wakeValidQ(wakeValid), .wakeMaskQ(wakeMask)
  );

  itc_cell_dp #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(accData),
    .count(dpCount), .semIsZero(semIsZero), .semIsOne(semIsOne),
    .semIsMax(semIsMax), .rdData(rspData)
  );

  assign tagWord = {{PAD_W{1'b0}}, 3'(DEPTH_LOG2),
                    (fifoMode ? dpCount : CNT_W'(0)),
                    fifoMode, trapEn, fullQ, emptyQ};

endmodule

// File: tb/itc_cell_tb.sv
module itc_cell_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgFifoMode = 1'b0, cfgTrap = 1'b0;
  logic        accEn = 1'b0, accWrite = 1'b0;
  logic [5:0]  accTid = '0;
  logic [63:0] accData = '0;
  logic        rspValid, rspBlocked, rspTrap, wakeValid;
  logic [63:0] rspData, wakeMask, blockedMap;
  logic [15:0] tagWord;

  itc_cell u_dut (.*);

  always #2 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference model state
  logic [63:0] q[$];
  bit          mMode = 1, mTrap = 0;
  logic [63:0] mSem = '0, mMap = '0;
  bit          eValid = 0, eBlk = 0, eTrap = 0, eWake = 0;
  logic [63:0] eData = '0, eMask = '0;
  string       tagReq = "R1";

  function automatic bit mEmpty(); return mMode ? (q.size() == 0) : (mSem == 0); endfunction
  function automatic bit mFull();  return mMode && (q.size() == 4); endfunction
  function automatic logic [15:0] mTag();
    logic [2:0] c = mMode ? 3'(q.size()) : 3'd0;
    return {6'd0, 3'd2, c, mMode, mTrap, mFull(), mEmpty()};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk({tagReq, " tag"}, 64'(tagWord), 64'(mTag()));
    chk("R9 rspValid", 64'(rspValid), 64'(eValid));
    chk("R3 rspData", rspData, eData);
    chk("R5 rspBlocked", 64'(rspBlocked), 64'(eBlk));
    chk("R5 blockedMap", blockedMap, mMap);
    chk("R7 rspTrap", 64'(rspTrap), 64'(eTrap));
    chk("R6 wakeValid", 64'(wakeValid), 64'(eWake));
    chk("R6 wakeMask", wakeMask, eMask);
  endtask

  task automatic modelStep(bit cw, bit cm, bit ct, bit en, bit wr, logic [5:0] tid, logic [63:0] d);
    bit oE, oF, blk;
    eValid = 0; eBlk = 0; eTrap = 0; eWake = 0; eData = '0; eMask = '0;
    if (cw) begin
      mMode = cm; mTrap = ct; q.delete(); mSem = '0;
      tagReq = "R8";
    end else if (en) begin
      eValid = 1;
      oE = mEmpty(); oF = mFull();
      blk = mMode ? (wr ? oF : oE) : (!wr && oE);
      if (blk) begin
        if (mTrap) eTrap = 1;
        else begin eBlk = 1; mMap[tid] = 1'b1; end
      end else begin
        if (mMode) begin
          if (wr) q.push_back(d);
          else eData = q.pop_front();
        end else begin
          if (wr) begin if (mSem != '1) mSem = mSem + 1; end
          else begin eData = mSem; mSem = mSem - 1; end
        end
        if ((oE != mEmpty() || oF != mFull()) && mMap != 0) begin
          eWake = 1; eMask = mMap; mMap = '0;
        end
      end
      tagReq = mMode ? "R2" : "R4";
    end
  endtask

  task automatic drive(bit cw, bit cm, bit ct, bit en, bit wr, logic [5:0] tid, logic [63:0] d);
    @(negedge clk);
    compareAll();
    cfgWrEn = cw; cfgFifoMode = cm; cfgTrap = ct;
    accEn = en; accWrite = wr; accTid = tid; accData = d;
    modelStep(cw, cm, ct, en, wr, tid, d);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int bias;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state, then R2/R5/R6: fill, overflow-block, pop wakes
    for (int i = 0; i < 5; i++) drive(0, 0, 0, 1, 1, 6'(i + 3), 64'hA000 + 64'(i));
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 1, 0, 6'd63, '0);
    drive(0, 0, 0, 1, 1, 6'd1, 64'hBEEF);   // R6 wake on empty change
    // R7 trap mode on queue
    drive(1, 1, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 6'd9, 0);
    // R4 semaphore, R8 access with config ignored
    drive(1, 0, 0, 1, 1, 6'd2, 0);
    drive(0, 0, 0, 1, 0, 6'd4, 0);
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 1, 1, 6'd5, 0);
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 1, 0, 6'd6, 0);
    drive(1, 1, 0, 0, 0, 0, 0);
    bias = 50;
    for (int n = 0; n < 6000; n++) begin
      bit cw = ($urandom_range(0, 149) == 0);
      if (n % 40 == 0) bias = $urandom_range(0, 1) ? 75 : 25;
      drive(cw, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0),
            1'($urandom_range(0, 9) < 8), 1'($urandom_range(0, 99) < bias),
            6'($urandom), {$urandom, $urandom});
    end
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    summary();
  end
endmodule